// File: doc/BRIEF.md
# Transceiver Channel Bring-Up Sequencer

This block steers a serial transceiver channel from cold power-down to a usable link. The channel's reference clock is reprogrammed after the board boots. While that happens the sequencer holds the channel in its deepest power-down state, with the PLL and both datapaths in reset. Once a clock-stable indication arrives, it powers the channel up and releases the PLL reset. It then waits for PLL lock and releases the transmit and receive datapath resets together.

The two directions finish their reset at different times. Link-ready is raised only after both have reported done, in whichever order they arrive. A watchdog bounds the wait for lock: if lock does not come in time, the channel is sent back to power-down for one cycle and the attempt starts again. If lock is lost after power-up, the sequencer goes back to the lock-wait state. If the clock-stable indication drops in any state, the sequencer returns to power-down.

All four status inputs are asynchronous to the sequencer clock. Each one passes through a two-flop synchronizer before use. All outputs come straight from flops.

Top module: `xcvr_bringup_seq`

## Requirements
- R1: During and right after reset, the outputs are: power state 2'b10 (deepest power-down), PLL reset high, TX reset high, RX reset high, link-ready low.
- R2: While the clock-stable input is low, the outputs stay in the R1 power-down pattern. When it rises, the power state becomes 2'b00 (fully on) exactly 3 clock edges later (2 synchronizer edges plus 1 register edge).
- R3: While the sequencer waits for lock, the outputs are: power state 2'b00, PLL reset low, TX reset high, RX reset high, link-ready low.
- R4: A rising PLL lock input lowers the TX and RX resets together, exactly 3 clock edges later.
- R5: Link-ready rises only after both the TX done and the RX done inputs have been seen high while the datapath resets are released. This holds in either arrival order. Link-ready rises exactly 3 edges after the later of the two.
- R6: If lock has not been seen after LOCK_TIMEOUT cycles of lock wait, the power state returns to 2'b10 for exactly one cycle. If clock-stable is still high, a new lock wait then begins.
- R7: A loss of PLL lock after the datapath resets have been released does three things 3 edges later: it drops link-ready, raises the TX and RX resets again, and returns to the R3 lock-wait pattern.
- R8: A falling clock-stable input returns the outputs to the R1 power-down pattern 3 edges later, from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refclk_ok_i | input | 1 | Reference clock reports stable (asynchronous) |
| pll_lock_i | input | 1 | Channel PLL lock flag (asynchronous) |
| tx_rst_done_i | input | 1 | Transmit datapath reset finished (asynchronous) |
| rx_rst_done_i | input | 1 | Receive datapath reset finished (asynchronous) |
| pwr_state_o | output | 2 | Channel power state: 2'b00 on, 2'b10 deepest down |
| pll_rst_o | output | 1 | PLL reset request |
| tx_rst_o | output | 1 | Transmit datapath reset request |
| rx_rst_o | output | 1 | Receive datapath reset request |
| link_ready_o | output | 1 | Link ready, registered |

## Verification
The bench builds the sequencer with LOCK_TIMEOUT = 8192. Its channel model takes 6180 cycles to lock, so a normal bring-up completes inside the bound. A withheld lock, by contrast, reaches the timeout and retry path after only about eight thousand cycles.

The model's TX and RX done latencies are first 270 and 1760 cycles, then 1900 and 100 cycles. This exercises both arrival orders of done.

The bench also drops lock while the link is up and drops clock-stable mid-run. It checks each recovery, and the exact synchronizer latency, against the cycle on which the model changed the input.

// File: rtl/xcvr_bringup_pkg.sv
package xcvr_bringup_pkg;

  localparam logic [1:0] PWR_ON   = 2'b00;
  localparam logic [1:0] PWR_DOWN = 2'b10;

  typedef enum logic [1:0] {
    ST_PDOWN    = 2'd0,
    ST_LOCK_WT  = 2'd1,
    ST_DP_WT    = 2'd2,
    ST_UP       = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic [1:0] pwr;
    logic       pll_rst;
    logic       tx_rst;
    logic       rx_rst;
    logic       ready;
  } seq_out_t;

  function automatic seq_out_t state_outputs(seq_state_e s);
    seq_out_t o;
    o = '{pwr: PWR_DOWN, pll_rst: 1'b1, tx_rst: 1'b1, rx_rst: 1'b1, ready: 1'b0};
    case (s)
      ST_LOCK_WT: o = '{pwr: PWR_ON, pll_rst: 1'b0, tx_rst: 1'b1, rx_rst: 1'b1, ready: 1'b0};
      ST_DP_WT:   o = '{pwr: PWR_ON, pll_rst: 1'b0, tx_rst: 1'b0, rx_rst: 1'b0, ready: 1'b0};
      ST_UP:      o = '{pwr: PWR_ON, pll_rst: 1'b0, tx_rst: 1'b0, rx_rst: 1'b0, ready: 1'b1};
      default:    ;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/xbs_sync.sv
module xbs_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] chain_q [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= '0;
          else        chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= '0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/xbs_watchdog.sv
module xbs_watchdog #(
  parameter int LIMIT = 16384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expired_o
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + 1'b1;
    else            cnt_q <= '0;
  end

  assign expired_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/xbs_fsm.sv
module xbs_fsm
  import xcvr_bringup_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clk_ok_i,
  input  logic     locked_i,
  input  logic     tx_done_i,
  input  logic     rx_done_i,
  input  logic     wd_expired_i,
  output logic     wd_run_o,
  output seq_out_t out_o
);

  seq_state_e state_q, state_d;
  logic       tx_seen_q, rx_seen_q;
  logic       tx_ok, rx_ok;
  seq_out_t   out_q;

  assign tx_ok = tx_seen_q | tx_done_i;
  assign rx_ok = rx_seen_q | rx_done_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_PDOWN:   if (clk_ok_i) state_d = ST_LOCK_WT;
      ST_LOCK_WT: begin
        if (!clk_ok_i)         state_d = ST_PDOWN;
        else if (locked_i)     state_d = ST_DP_WT;
        else if (wd_expired_i) state_d = ST_PDOWN;
      end
      ST_DP_WT: begin
        if (!clk_ok_i)          state_d = ST_PDOWN;
        else if (!locked_i)     state_d = ST_LOCK_WT;
        else if (tx_ok && rx_ok) state_d = ST_UP;
      end
      ST_UP: begin
        if (!clk_ok_i)      state_d = ST_PDOWN;
        else if (!locked_i) state_d = ST_LOCK_WT;
      end
      default: state_d = ST_PDOWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_PDOWN;
      tx_seen_q <= 1'b0;
      rx_seen_q <= 1'b0;
      out_q     <= state_outputs(ST_PDOWN);
    end else begin
      state_q <= state_d;
      out_q   <= state_outputs(state_d);
      if (state_q == ST_DP_WT && state_d == ST_DP_WT) begin
        tx_seen_q <= tx_ok;
        rx_seen_q <= rx_ok;
      end else begin
        tx_seen_q <= 1'b0;
        rx_seen_q <= 1'b0;
      end
    end
  end

  assign wd_run_o = (state_q == ST_LOCK_WT);
  assign out_o    = out_q;

endmodule

// File: rtl/xcvr_bringup_seq.sv
module xcvr_bringup_seq
  import xcvr_bringup_pkg::*;
#(
  parameter int LOCK_TIMEOUT = 16384,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       refclk_ok_i,
  input  logic       pll_lock_i,
  input  logic       tx_rst_done_i,
  input  logic       rx_rst_done_i,
  output logic [1:0] pwr_state_o,
  output logic       pll_rst_o,
  output logic       tx_rst_o,
  output logic       rx_rst_o,
  output logic       link_ready_o
);

  localparam int NSTAT = 4;

  logic [NSTAT-1:0] stat_async, stat_sync;
  logic             wd_run, wd_expired;
  seq_out_t         seq_out;

  assign stat_async = {refclk_ok_i, pll_lock_i, tx_rst_done_i, rx_rst_done_i};

  xbs_sync #(.WIDTH(NSTAT), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (stat_async),
    .sync_o  (stat_sync)
  );

  xbs_watchdog #(.LIMIT(LOCK_TIMEOUT)) u_wd (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (wd_run),
    .expired_o (wd_expired)
  );

  xbs_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .clk_ok_i     (stat_sync[3]),
    .locked_i     (stat_sync[2]),
    .tx_done_i    (stat_sync[1]),
    .rx_done_i    (stat_sync[0]),
    .wd_expired_i (wd_expired),
    .wd_run_o     (wd_run),
    .out_o        (seq_out)
  );

  assign pwr_state_o  = seq_out.pwr;
  assign pll_rst_o    = seq_out.pll_rst;
  assign tx_rst_o     = seq_out.tx_rst;
  assign rx_rst_o     = seq_out.rx_rst;
  assign link_ready_o = seq_out.ready;

endmodule

// File: rtl/xbs_checker.sv
module xbs_checker #(
  parameter int LOCK_TIMEOUT = 16384
) (
  input logic       clk,
  input logic       rst_n,
  input logic       refclk_ok_i,
  input logic       pll_lock_i,
  input logic [1:0] pwr_state_o,
  input logic       pll_rst_o,
  input logic       tx_rst_o,
  input logic       rx_rst_o,
  input logic       link_ready_o
);

  localparam int CW = $clog2(LOCK_TIMEOUT + 1) + 1;

  logic          in_lock_wait;
  logic [CW-1:0] wait_cnt_q;

  assign in_lock_wait = (pwr_state_o == 2'b00) && tx_rst_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            wait_cnt_q <= '0;
    else if (in_lock_wait) wait_cnt_q <= wait_cnt_q + 1'b1;
    else                   wait_cnt_q <= '0;
  end

  a_r1_pdown_holds_all_resets: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state_o == 2'b10) |-> (pll_rst_o && tx_rst_o && rx_rst_o && !link_ready_o));

  a_r2_wake_goes_to_lock_wait: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_state_o) == 2'b10 && pwr_state_o != 2'b10) |->
      (pwr_state_o == 2'b00 && !pll_rst_o && tx_rst_o && rx_rst_o));

  a_r4_release_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_rst_o) |-> $past(pll_lock_i, 2));

  a_r5_ready_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_ready_o) |-> ($past(!tx_rst_o) && $past(!rx_rst_o)));

  a_r5_ready_only_when_up: assert property (@(posedge clk) disable iff (!rst_n)
    link_ready_o |-> (pwr_state_o == 2'b00 && !pll_rst_o && !tx_rst_o && !rx_rst_o));

  a_r6_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    in_lock_wait |-> (wait_cnt_q < CW'(LOCK_TIMEOUT)));

  a_r8_pdown_needs_clk_drop: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pwr_state_o == 2'b10) && $past(link_ready_o)) |-> !$past(refclk_ok_i, 2));

endmodule

bind xcvr_bringup_seq xbs_checker #(.LOCK_TIMEOUT(LOCK_TIMEOUT)) u_xbs_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .refclk_ok_i  (refclk_ok_i),
  .pll_lock_i   (pll_lock_i),
  .pwr_state_o  (pwr_state_o),
  .pll_rst_o    (pll_rst_o),
  .tx_rst_o     (tx_rst_o),
  .rx_rst_o     (rx_rst_o),
  .link_ready_o (link_ready_o)
);

// File: tb/test_xcvr_bringup_seq.sv
`timescale 1ns/1ps
module test_xcvr_bringup_seq;

  localparam int LOCK_TIMEOUT = 8192;
  localparam int LOCK_DLY     = 6180;

  localparam logic [5:0] V_PDOWN = 6'b10_1110;
  localparam logic [5:0] V_LWAIT = 6'b00_0110;
  localparam logic [5:0] V_DWAIT = 6'b00_0000;
  localparam logic [5:0] V_UP    = 6'b00_0001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic refclk_ok = 1'b0;
  logic pll_lock = 1'b0;
  logic tx_done = 1'b0;
  logic rx_done = 1'b0;
  logic [1:0] pwr;
  logic pll_rst, tx_rst, rx_rst, ready;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 1'b0;

  bit lock_en = 1'b1;
  int tx_dly = 270;
  int rx_dly = 1760;
  int lk_cnt = 0, tx_cnt = 0, rx_cnt = 0;
  int lock_rise_cyc = 0, lock_fall_cyc = 0, tx_rise_cyc = 0, rx_rise_cyc = 0;

  logic [5:0] exp_q [$];
  string      tag_q [$];
  int         chg_q [$];
  logic [5:0] last_vec;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  xcvr_bringup_seq #(.LOCK_TIMEOUT(LOCK_TIMEOUT)) i_xcvr_bringup_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .refclk_ok_i   (refclk_ok),
    .pll_lock_i    (pll_lock),
    .tx_rst_done_i (tx_done),
    .rx_rst_done_i (rx_done),
    .pwr_state_o   (pwr),
    .pll_rst_o     (pll_rst),
    .tx_rst_o      (tx_rst),
    .rx_rst_o      (rx_rst),
    .link_ready_o  (ready)
  );

  wire [5:0] out_vec = {pwr, pll_rst, tx_rst, rx_rst, ready};

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic expect_vec(logic [5:0] v, string req);
    exp_q.push_back(v);
    tag_q.push_back(req);
  endtask

  task automatic wait_drain(string req);
    int n = 0;
    while (exp_q.size() != 0 && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (exp_q.size() != 0) check({req, " queue drain"}, exp_q.size(), 0);
  endtask

  // Channel model: lock, TX done and RX done with their own latencies
  always @(negedge clk) begin
    if (rst_n) begin
      if (pwr == 2'b00 && !pll_rst && lock_en) begin
        if (lk_cnt < LOCK_DLY) lk_cnt++;
        else if (!pll_lock) begin pll_lock = 1'b1; lock_rise_cyc = cyc; end
      end else begin
        lk_cnt = 0;
        if (pll_lock) begin pll_lock = 1'b0; lock_fall_cyc = cyc; end
      end
      if (!tx_rst) begin
        if (tx_cnt < tx_dly) tx_cnt++;
        else if (!tx_done) begin tx_done = 1'b1; tx_rise_cyc = cyc; end
      end else begin tx_cnt = 0; tx_done = 1'b0; end
      if (!rx_rst) begin
        if (rx_cnt < rx_dly) rx_cnt++;
        else if (!rx_done) begin rx_done = 1'b1; rx_rise_cyc = cyc; end
      end else begin rx_cnt = 0; rx_done = 1'b0; end
    end
  end

  // Monitor: every output change pops and compares one expected pattern
  always @(negedge clk) begin
    if (rst_n && out_vec != last_vec) begin
      if (exp_q.size() == 0) begin
        check("unexpected output change", int'(out_vec), int'(last_vec));
      end else begin
        logic [5:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, int'(out_vec), int'(e));
      end
      chg_q.push_back(cyc);
      last_vec = out_vec;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int mark, t0;
    last_vec = V_PDOWN;
    repeat (3) @(negedge clk);
    check("R1 outputs held in reset", int'(out_vec), int'(V_PDOWN));
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 outputs after reset", int'(out_vec), int'(V_PDOWN));

    // R2: clock not yet stable, channel stays down
    repeat (500) @(negedge clk);
    check("R2 held down while clock unstable", int'(out_vec), int'(V_PDOWN));

    // First bring-up: TX done before RX done
    expect_vec(V_LWAIT, "R3 lock-wait pattern");
    expect_vec(V_DWAIT, "R4 resets released on lock");
    expect_vec(V_UP,    "R5 ready after both done (TX first)");
    chg_q.delete();
    @(negedge clk);
    refclk_ok = 1'b1;
    mark = cyc;
    wait_drain("R5");
    check("R2 wake latency", chg_q[0] - mark, 3);
    check("R4 lock to release latency", chg_q[1] - lock_rise_cyc, 3);
    check("R5 order TX then RX", int'(rx_rise_cyc > tx_rise_cyc), 1);
    check("R5 ready latency after RX done", chg_q[2] - rx_rise_cyc, 3);

    // R7: lock loss while up
    repeat (50) @(negedge clk);
    expect_vec(V_LWAIT, "R7 back to lock wait on lock loss");
    expect_vec(V_DWAIT, "R7 release on relock");
    expect_vec(V_UP,    "R7 ready again");
    chg_q.delete();
    @(posedge clk); lock_en = 1'b0;
    repeat (100) @(negedge clk);
    check("R7 ready dropped during lock loss", int'(ready), 0);
    check("R7 resets re-held during lock loss", int'({tx_rst, rx_rst}), 3);
    @(posedge clk); lock_en = 1'b1;
    wait_drain("R7");
    check("R7 lock loss latency", chg_q[0] - lock_fall_cyc, 3);

    // R8: clock-stable drop from up state
    repeat (20) @(negedge clk);
    expect_vec(V_PDOWN, "R8 power-down on clock drop");
    chg_q.delete();
    @(negedge clk);
    refclk_ok = 1'b0;
    mark = cyc;
    wait_drain("R8");
    check("R8 clock drop latency", chg_q[0] - mark, 3);

    // R5 again with RX before TX
    tx_dly = 1900;
    rx_dly = 100;
    repeat (40) @(negedge clk);
    expect_vec(V_LWAIT, "R3 lock-wait pattern (second)");
    expect_vec(V_DWAIT, "R4 release (second)");
    expect_vec(V_UP,    "R5 ready after both done (RX first)");
    chg_q.delete();
    @(negedge clk); refclk_ok = 1'b1;
    wait_drain("R5b");
    check("R5 order RX then TX", int'(tx_rise_cyc > rx_rise_cyc), 1);
    check("R5 ready latency after TX done", chg_q[2] - tx_rise_cyc, 3);

    // R6: withheld lock triggers timeout and retry
    expect_vec(V_PDOWN, "R8 power-down before timeout test");
    @(negedge clk); refclk_ok = 1'b0;
    wait_drain("R8b");
    @(posedge clk); lock_en = 1'b0;
    repeat (10) @(negedge clk);
    expect_vec(V_LWAIT, "R6 first lock wait");
    expect_vec(V_PDOWN, "R6 timeout power-down");
    expect_vec(V_LWAIT, "R6 retry lock wait");
    chg_q.delete();
    @(negedge clk); refclk_ok = 1'b1;
    wait_drain("R6");
    t0 = chg_q[0];
    check("R6 lock-wait dwell equals timeout", chg_q[1] - t0, LOCK_TIMEOUT);
    check("R6 retry power-down lasts one cycle", chg_q[2] - chg_q[1], 1);
    expect_vec(V_DWAIT, "R6 release after retry lock");
    expect_vec(V_UP,    "R6 ready after retry");
    @(posedge clk); lock_en = 1'b1;
    wait_drain("R6b");
    check("R6 link up after retry", int'(ready), 1);

    repeat (20) @(negedge clk);
    check("scoreboard empty at end", exp_q.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule